// File: doc/BRIEF.md
# PWM Channel Output Comparator

This block drives one PWM pin from the count of a shared timer. Four free-running timers are fed in as count buses, each with a one-cycle overflow pulse marking the last count of its period. The channel picks one of them, raises its pin when the count reaches a programmed high point, and drops it again after a programmed number of counts. The duty value carries a binary fraction below the integer count. A dither accumulator spreads that fraction over sixteen periods as single extra high counts, so the average duty is finer than the timer resolution.

The timer choice, high point, duty, output enable and overflow-count enable are written into staging registers. They are copied into the working set only after a self-clearing update strobe, and only at the next overflow of the timer currently in use, so no period is ever cut short. While the output is disabled, the pin follows an idle level that acts at once. A separate counter tallies overflows of the selected timer and gives a one-cycle interrupt pulse each time a programmed number of them has been reached. The duty in effect can be read back at all times.

Top module: `pwm_chan_cmp`

## Requirements
- R1: The 4-bit selector in CTRL (address 0, bits 7:4) chooses which timer's count and overflow pulse drive the channel, with values 0 to 3.
- R2: While the working output enable (CTRL bit 0) is 0, the pin follows the idle level (CTRL bit 1) one cycle after it is written, with no update strobe needed.
- R3: With the output enabled, the pin rises in the cycle after the selected count equals the working high point (address 1, low 20 bits).
- R4: The integer duty (address 2, bits 24:4) sets how many counts the pin stays high after the high point. An integer duty of zero with zero fraction keeps the pin low.
- R5: The duty fraction (address 2, bits 3:0) adds one extra high count in exactly that many of every 16 consecutive periods.
- R6: Writes to addresses 1 and 2 and to the CTRL fields have no effect on the working set until CTRL bit 8 (update strobe) is written as 1. The staged values then take effect at the first overflow of the working timer after the strobe.
- R7: On an update, the working duty is loaded only if the staged duty-start flag (CTRL bit 3) is 1. Otherwise the working duty stays as it was.
- R8: With the working overflow-count enable (CTRL bit 2) set, the interrupt gives a one-cycle pulse after every limit+1 overflows of the selected timer, where the 10-bit limit is at address 3. With the enable clear, no pulse occurs.
- R9: Writing CTRL bit 9 as 1 restarts the overflow tally from zero, so the next pulse needs a full limit+1 further overflows.
- R10: After reset the pin, the interrupt and the duty readback are all 0.
- R11: The duty readback always equals the working duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_cnt_i | input | NUM_TMR*CNT_W | Packed timer counts, timer k in bits k*CNT_W upward |
| tmr_ovf_i | input | NUM_TMR | Overflow pulse per timer, high on the last count of a period |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | DUTY_W | Register write data |
| pwm_o | output | 1 | PWM pin |
| irq_o | output | 1 | Overflow-count interrupt pulse |
| duty_now_o | output | DUTY_W | Working duty readback |

## Verification
The hardest case to reach from the ports is the fractional dither: its effect only shows as a single extra high count in a few periods out of sixteen, and it depends on an accumulator phase that cannot be seen. The stimulus therefore holds each setting for exactly sixteen periods of the chosen timer and counts high cycles over that window. That window contains every accumulator phase once, so the total does not depend on where the window starts. The deferred update is reached by placing the strobe just after an overflow and checking the readback both before and after the next one.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_HPT    = 2'd1,
      REG_DUTY   = 2'd2,
      REG_OVFLIM = 2'd3
   } reg_addr_e;

   // control word bit positions
   localparam int CB_OUT_EN  = 0;
   localparam int CB_IDLE    = 1;
   localparam int CB_OVF_EN  = 2;
   localparam int CB_DSTART  = 3;
   localparam int CB_SEL_LO  = 4;
   localparam int CB_SEL_MAX = 4;
   localparam int CB_UPD     = 8;
   localparam int CB_OVF_CLR = 9;
   localparam int CB_TOP     = 10;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
   import pwm_cmp_pkg::*;
#(
   parameter int CNT_W  = 20,
   parameter int DUTY_W = 25,
   parameter int SEL_W  = 2,
   parameter int OVF_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DUTY_W-1:0] wr_data,
   input  logic              sel_ovf,
   output logic              act_out_en,
   output logic [SEL_W-1:0]  act_sel,
   output logic [CNT_W-1:0]  act_hpt,
   output logic [DUTY_W-1:0] act_duty,
   output logic              act_ovf_en,
   output logic              idle_lvl,
   output logic [OVF_W-1:0]  ovf_lim,
   output logic              ovf_clr,
   output logic              apply,
   output logic              start_low
);

   logic              sh_out_en, sh_ovf_en, sh_dstart, pend_q;
   logic [SEL_W-1:0]  sh_sel;
   logic [CNT_W-1:0]  sh_hpt;
   logic [DUTY_W-1:0] sh_duty;
   logic              wr_ctrl, wr_hpt, wr_duty, wr_lim;

   assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
   assign wr_hpt    = wr_en && (wr_addr == REG_HPT);
   assign wr_duty   = wr_en && (wr_addr == REG_DUTY);
   assign wr_lim    = wr_en && (wr_addr == REG_OVFLIM);

   assign apply     = pend_q && sel_ovf;
   assign start_low = apply && sh_out_en && !act_out_en;
   assign ovf_clr   = wr_ctrl && wr_data[CB_OVF_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_out_en  <= 1'b0;
         sh_ovf_en  <= 1'b0;
         sh_dstart  <= 1'b0;
         sh_sel     <= '0;
         sh_hpt     <= '0;
         sh_duty    <= '0;
         pend_q     <= 1'b0;
         idle_lvl   <= 1'b0;
         ovf_lim    <= '0;
         act_out_en <= 1'b0;
         act_sel    <= '0;
         act_hpt    <= '0;
         act_duty   <= '0;
         act_ovf_en <= 1'b0;
      end else begin
         if (apply) begin
            act_out_en <= sh_out_en;
            act_sel    <= sh_sel;
            act_hpt    <= sh_hpt;
            act_ovf_en <= sh_ovf_en;
            if (sh_dstart) begin
               act_duty <= sh_duty;
            end
            pend_q <= 1'b0;
         end
         if (wr_ctrl) begin
            sh_out_en <= wr_data[CB_OUT_EN];
            idle_lvl  <= wr_data[CB_IDLE];
            sh_ovf_en <= wr_data[CB_OVF_EN];
            sh_dstart <= wr_data[CB_DSTART];
            sh_sel    <= wr_data[CB_SEL_LO +: SEL_W];
            if (wr_data[CB_UPD]) begin
               pend_q <= 1'b1;
            end
         end
         if (wr_hpt) begin
            sh_hpt <= wr_data[CNT_W-1:0];
         end
         if (wr_duty) begin
            sh_duty <= wr_data;
         end
         if (wr_lim) begin
            ovf_lim <= wr_data[OVF_W-1:0];
         end
      end
   end

endmodule

// File: rtl/pwm_tmr_mux.sv
module pwm_tmr_mux #(
   parameter int NUM_TMR = 4,
   parameter int CNT_W   = 20,
   parameter int SEL_W   = 2
) (
   input  logic [NUM_TMR*CNT_W-1:0] cnt_bus,
   input  logic [NUM_TMR-1:0]       ovf_bus,
   input  logic [SEL_W-1:0]         sel,
   output logic [CNT_W-1:0]         cnt,
   output logic                     ovf
);

   generate
      if (NUM_TMR == 1) begin : g_single
         assign cnt = cnt_bus;
         assign ovf = ovf_bus[0];
      end else begin : g_multi
         logic [CNT_W-1:0] lane [NUM_TMR];
         for (genvar i = 0; i < NUM_TMR; i++) begin : g_lane
            assign lane[i] = cnt_bus[i*CNT_W +: CNT_W];
         end
         always_comb begin
            cnt = '0;
            ovf = 1'b0;
            for (int i = 0; i < NUM_TMR; i++) begin
               if (sel == SEL_W'(i)) begin
                  cnt = lane[i];
                  ovf = ovf_bus[i];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen #(
   parameter int CNT_W  = 20,
   parameter int DUTY_W = 25,
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              ovf,
   input  logic              out_en,
   input  logic              idle_lvl,
   input  logic              start_low,
   input  logic [CNT_W-1:0]  hpt,
   input  logic [DUTY_W-1:0] duty,
   output logic              pwm
);

   localparam int DINT_W = DUTY_W - FRAC_W;
   localparam int LP_W   = DINT_W + 2;

   logic            extra;
   logic [LP_W-1:0] span, lpt;
   logic            hit_h, hit_l;

   generate
      if (FRAC_W > 0) begin : g_dither
         logic [FRAC_W-1:0] acc_q;
         logic              extra_q;
         logic [FRAC_W:0]   sum;
         assign sum = {1'b0, acc_q} + {1'b0, duty[FRAC_W-1:0]};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q   <= '0;
               extra_q <= 1'b0;
            end else if (ovf) begin
               acc_q   <= sum[FRAC_W-1:0];
               extra_q <= sum[FRAC_W];
            end
         end
         assign extra = extra_q;
      end else begin : g_plain
         assign extra = 1'b0;
      end
   endgenerate

   assign span  = LP_W'(duty[DUTY_W-1:FRAC_W]) + LP_W'(extra);
   assign lpt   = LP_W'(hpt) + span;
   assign hit_h = (cnt == hpt);
   assign hit_l = (LP_W'(cnt) == lpt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm <= 1'b0;
      end else if (start_low) begin
         pwm <= 1'b0;
      end else if (!out_en) begin
         pwm <= idle_lvl;
      end else if (hit_l) begin
         pwm <= 1'b0;
      end else if (hit_h) begin
         pwm <= 1'b1;
      end
   end

endmodule

// File: rtl/pwm_ovf_counter.sv
module pwm_ovf_counter #(
   parameter int OVF_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ovf,
   input  logic             clr,
   input  logic [OVF_W-1:0] limit,
   output logic             irq
);

   logic [OVF_W-1:0] tally_q;
   logic             reach;

   assign reach = (tally_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tally_q <= '0;
         irq     <= 1'b0;
      end else begin
         irq <= !clr && en && ovf && reach;
         if (clr) begin
            tally_q <= '0;
         end else if (en && ovf) begin
            tally_q <= reach ? '0 : tally_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp
   import pwm_cmp_pkg::*;
#(
   parameter int NUM_TMR = 4,
   parameter int CNT_W   = 20,
   parameter int FRAC_W  = 4,
   parameter int DUTY_W  = 25,
   parameter int OVF_W   = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_TMR*CNT_W-1:0] tmr_cnt_i,
   input  logic [NUM_TMR-1:0]       tmr_ovf_i,
   input  logic                     wr_en_i,
   input  logic [1:0]               wr_addr_i,
   input  logic [DUTY_W-1:0]        wr_data_i,
   output logic                     pwm_o,
   output logic                     irq_o,
   output logic [DUTY_W-1:0]        duty_now_o
);

   localparam int SEL_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

   generate
      if (NUM_TMR < 1 || SEL_W > CB_SEL_MAX) begin : g_bad_tmr
         $error("pwm_chan_cmp: NUM_TMR out of range");
      end
      if (DUTY_W - FRAC_W < CNT_W) begin : g_bad_duty
         $error("pwm_chan_cmp: integer duty narrower than timer count");
      end
      if (DUTY_W < CB_TOP || OVF_W > DUTY_W || FRAC_W < 0) begin : g_bad_word
         $error("pwm_chan_cmp: write word too narrow for fields");
      end
   endgenerate

   logic              act_out_en, act_ovf_en, idle_lvl;
   logic              ovf_clr, apply, start_low;
   logic [SEL_W-1:0]  act_sel;
   logic [CNT_W-1:0]  act_hpt, sel_cnt;
   logic [DUTY_W-1:0] act_duty;
   logic [OVF_W-1:0]  ovf_lim;
   logic              sel_ovf;

   pwm_cfg_regs #(
      .CNT_W (CNT_W),
      .DUTY_W(DUTY_W),
      .SEL_W (SEL_W),
      .OVF_W (OVF_W)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en_i),
      .wr_addr   (wr_addr_i),
      .wr_data   (wr_data_i),
      .sel_ovf   (sel_ovf),
      .act_out_en(act_out_en),
      .act_sel   (act_sel),
      .act_hpt   (act_hpt),
      .act_duty  (act_duty),
      .act_ovf_en(act_ovf_en),
      .idle_lvl  (idle_lvl),
      .ovf_lim   (ovf_lim),
      .ovf_clr   (ovf_clr),
      .apply     (apply),
      .start_low (start_low)
   );

   pwm_tmr_mux #(
      .NUM_TMR(NUM_TMR),
      .CNT_W  (CNT_W),
      .SEL_W  (SEL_W)
   ) i_mux (
      .cnt_bus(tmr_cnt_i),
      .ovf_bus(tmr_ovf_i),
      .sel    (act_sel),
      .cnt    (sel_cnt),
      .ovf    (sel_ovf)
   );

   pwm_wave_gen #(
      .CNT_W (CNT_W),
      .DUTY_W(DUTY_W),
      .FRAC_W(FRAC_W)
   ) i_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (sel_cnt),
      .ovf      (sel_ovf),
      .out_en   (act_out_en),
      .idle_lvl (idle_lvl),
      .start_low(start_low),
      .hpt      (act_hpt),
      .duty     (act_duty),
      .pwm      (pwm_o)
   );

   pwm_ovf_counter #(
      .OVF_W(OVF_W)
   ) i_ovf (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (act_ovf_en),
      .ovf  (sel_ovf),
      .clr  (ovf_clr),
      .limit(ovf_lim),
      .irq  (irq_o)
   );

   assign duty_now_o = act_duty;

endmodule

// File: rtl/pwm_chan_cmp_chk.sv
module pwm_chan_cmp_chk #(
   parameter int CNT_W  = 20,
   parameter int DUTY_W = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwm_o,
   input logic              irq_o,
   input logic [DUTY_W-1:0] duty_now_o,
   input logic              act_out_en,
   input logic              idle_lvl,
   input logic              act_ovf_en,
   input logic              sel_ovf,
   input logic [CNT_W-1:0]  sel_cnt,
   input logic [CNT_W-1:0]  act_hpt,
   input logic              apply
);

   AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_out_en && $past(!act_out_en)) |-> (pwm_o == $past(idle_lvl))); // R2

   AST_RISE_AT_HPT: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_o) && $past(act_out_en)) |-> $past(sel_cnt == act_hpt)); // R3

   AST_IRQ_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(sel_ovf && act_ovf_en)); // R8

   AST_DUTY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(duty_now_o) |-> $past(apply)); // R6

endmodule

bind pwm_chan_cmp pwm_chan_cmp_chk #(
   .CNT_W (CNT_W),
   .DUTY_W(DUTY_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwm_o     (pwm_o),
   .irq_o     (irq_o),
   .duty_now_o(duty_now_o),
   .act_out_en(act_out_en),
   .idle_lvl  (idle_lvl),
   .act_ovf_en(act_ovf_en),
   .sel_ovf   (sel_ovf),
   .sel_cnt   (sel_cnt),
   .act_hpt   (act_hpt),
   .apply     (apply)
);

// File: tb/test_pwm_chan_cmp.sv
module test_pwm_chan_cmp;

   localparam int NT = 4;
   localparam int CW = 20;
   localparam int DW = 25;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NT*CW-1:0]  tmr_bus;
   logic [NT-1:0]     tmr_ovf;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_addr = 2'd0;
   logic [DW-1:0]     wr_data = '0;
   logic              pwm_o, irq_o;
   logic [DW-1:0]     duty_now_o;
   logic [CW-1:0]     tcnt [NT];

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   function automatic int per(int k);
      case (k)
         0: return 16;
         1: return 10;
         2: return 32;
         default: return 20;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      for (int k = 0; k < NT; k++) begin
         if (!rst_n) tcnt[k] <= '0;
         else tcnt[k] <= (tcnt[k] == CW'(per(k) - 1)) ? '0 : tcnt[k] + 1'b1;
      end
   end

   always_comb begin
      for (int k = 0; k < NT; k++) begin
         tmr_bus[k*CW +: CW] = tcnt[k];
         tmr_ovf[k] = (tcnt[k] == CW'(per(k) - 1));
      end
   end

   pwm_chan_cmp i_pwm_chan_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmr_cnt_i (tmr_bus),
      .tmr_ovf_i (tmr_ovf),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .pwm_o     (pwm_o),
      .irq_o     (irq_o),
      .duty_now_o(duty_now_o)
   );

   typedef struct packed {
      logic [3:0]  sel;
      logic [19:0] hpt;
      logic [20:0] dint;
      logic [3:0]  frac;
      int          high;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{4'd0, 20'd2,  21'd5,  4'd0,  80},
      '{4'd0, 20'd4,  21'd3,  4'd4,  52},
      '{4'd1, 20'd1,  21'd6,  4'd8,  104},
      '{4'd2, 20'd10, 21'd12, 4'd15, 207},
      '{4'd3, 20'd0,  21'd7,  4'd1,  113},
      '{4'd2, 20'd5,  21'd0,  4'd0,  0}
   };

   function automatic logic [DW-1:0] ctl(bit oe, bit idle, bit ovfe, bit ds,
                                         int sel, bit upd, bit clr);
      logic [DW-1:0] w;
      w = '0;
      w[0] = oe; w[1] = idle; w[2] = ovfe; w[3] = ds;
      w[7:4] = 4'(sel); w[8] = upd; w[9] = clr;
      return w;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_high(int n, output int h);
      h = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_o) h++;
      end
   endtask

   task automatic count_irq(int n, output int c);
      c = 0;
      repeat (n) begin
         @(negedge clk);
         if (irq_o) c++;
      end
   endtask

   task automatic wait_ovf0();
      do @(negedge clk); while (!tmr_ovf[0]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int h, c, n, rise;
      logic prevp;
      logic [DW-1:0] old_d, new_d;

      wait_cyc(5);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(pwm_o == 1'b0, "R10 pwm", pwm_o, 0);
      chk(irq_o == 1'b0, "R10 irq", irq_o, 0);
      chk(duty_now_o == '0, "R10 duty", duty_now_o, 0);

      // vector table: R1 R3 R4 R5 R11
      for (int v = 0; v < 6; v++) begin
         int s, p;
         s = int'(VECS[v].sel);
         p = per(s);
         new_d = {VECS[v].dint, VECS[v].frac};
         wr(2'd1, DW'(VECS[v].hpt));
         wr(2'd2, new_d);
         wr(2'd0, ctl(1, 0, 0, 1, s, 1, 0));
         wait_cyc(200);
         chk(duty_now_o == new_d, "R11 readback", duty_now_o, new_d);
         count_high(16 * p, h);
         chk(h == VECS[v].high, "R4/R5 high count over 16 periods", h, VECS[v].high);
         if (VECS[v].high != 0) begin
            rise = -1;
            prevp = pwm_o;
            for (int t = 0; t < 3 * p && rise < 0; t++) begin
               @(negedge clk);
               if (pwm_o && !prevp) rise = int'(tcnt[s]);
               prevp = pwm_o;
            end
            chk(rise == (int'(VECS[v].hpt) + 1) % p, "R1/R3 rise position",
                rise, (int'(VECS[v].hpt) + 1) % p);
         end
      end

      // R6 staged writes without strobe do nothing
      wr(2'd1, DW'(3));
      wr(2'd2, {21'd4, 4'd0});
      wr(2'd0, ctl(1, 0, 0, 1, 0, 1, 0));
      wait_cyc(120);
      old_d = duty_now_o;
      new_d = {21'd9, 4'd2};
      wr(2'd2, new_d);
      wait_cyc(60);
      chk(duty_now_o == old_d, "R6 no strobe keeps duty", duty_now_o, old_d);

      // R6 strobe applies only at next overflow
      wait_ovf0();
      wr(2'd0, ctl(1, 0, 0, 1, 0, 1, 0));
      wait_cyc(2);
      chk(duty_now_o == old_d, "R6 before overflow", duty_now_o, old_d);
      wait_ovf0();
      chk(duty_now_o == old_d, "R6 at overflow cycle", duty_now_o, old_d);
      @(negedge clk);
      chk(duty_now_o == new_d, "R6 after overflow", duty_now_o, new_d);

      // R7 duty-start clear keeps duty
      wr(2'd2, {21'd2, 4'd0});
      wr(2'd0, ctl(1, 0, 0, 0, 0, 1, 0));
      wait_cyc(60);
      chk(duty_now_o == new_d, "R7 duty kept", duty_now_o, new_d);

      // R2 idle level when disabled
      wr(2'd0, ctl(0, 1, 0, 1, 0, 1, 0));
      wait_cyc(60);
      count_high(32, h);
      chk(h == 32, "R2 idle high", h, 32);
      wr(2'd0, ctl(0, 0, 0, 1, 0, 0, 0));
      @(negedge clk);
      chk(pwm_o == 1'b0, "R2 idle immediate", pwm_o, 0);
      count_high(32, h);
      chk(h == 0, "R2 idle low", h, 0);

      // R8 interrupt rate
      wr(2'd3, DW'(2));
      wr(2'd0, ctl(1, 0, 1, 1, 0, 1, 0));
      wait_cyc(100);
      count_irq(48 * 16, c);
      chk(c == 16, "R8 irq per 3 overflows", c, 16);
      wr(2'd0, ctl(1, 0, 0, 1, 0, 1, 0));
      wait_cyc(60);
      count_irq(48 * 16, c);
      chk(c == 0, "R8 disabled no irq", c, 0);

      // R9 clear restarts the tally
      wr(2'd3, DW'(3));
      wr(2'd0, ctl(1, 0, 1, 1, 0, 1, 0));
      wait_cyc(60);
      n = 0;
      while (!irq_o && n < 400) begin
         @(negedge clk);
         n++;
      end
      wait_ovf0();
      wait_ovf0();
      wr(2'd0, ctl(1, 0, 1, 1, 0, 0, 1));
      n = 0;
      c = 0;
      while (!irq_o && c < 400) begin
         @(negedge clk);
         c++;
         if (tmr_ovf[0]) n++;
      end
      chk(n == 4, "R9 overflows after clear", n, 4);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule